// File: doc/BRIEF.md
# Page Write Buffer and Programming Cycle Sequencer

This block sits between a serial memory's protocol controller and its non-volatile array. During a write transaction the controller hands it data bytes one at a time, each with a full array address. The block keeps them in a page-sized holding register, and each held byte carries a flag that marks it as received. Every byte in one transaction goes to the same page: the page number comes from the first byte accepted, and only the low offset bits of later bytes are used. When the same offset is hit again, the newer byte replaces the older one.

When the controller reports the bus stop condition, the block starts an internally timed programming cycle if at least one byte is held. It walks the page offsets in ascending order and presents each flagged byte on the array write port. It then holds `busy` until a parameterised number of prescaler ticks has elapsed, so the controller can refuse new accesses during the cycle. At the end of the cycle every flag clears.

Bytes offered while write protection is active or while a cycle is running are dropped. A fresh bus start that arrives before the stop discards everything held.

Top module: `pcw_page_commit`

## Requirements
- R1: After reset `busy` is 0, `mem_we` is 0 and no byte is held, so a commit with no new bytes starts no cycle.
- R2: A byte accepted at offset `byte_addr[4:0]` is written to array address `{page, offset}` (page = upper six address bits) with its data, once the cycle runs.
- R3: Offsets are taken modulo 32. A later byte at an already-flagged offset replaces the earlier one, and that offset is written only once, with the newer value.
- R4: No array write occurs before a commit. `busy` rises in the first cycle after a commit edge that finds at least one held byte, and `mem_we` is asserted only while `busy` is 1.
- R5: `busy` stays 1 until `CYCLE_TICKS` ticks have been counted since the cycle started (and the offset walk has finished). It falls on the clock edge after the edge that registers the final tick.
- R6: A byte strobe with `wp` = 1 is not held. If only protected bytes were offered, a commit starts no cycle and produces no write.
- R7: Only flagged offsets are written, in ascending offset order within one cycle. All flags clear when the cycle ends, so a second commit with no new bytes starts no cycle.
- R8: A commit with no held bytes leaves `busy` at 0 and makes no writes.
- R9: `abort` while idle discards all held bytes. Bytes accepted after the abort are committed normally.
- R10: Byte strobes, commits and aborts that arrive while `busy` is 1 are ignored.
- R11: The page of a transaction is that of its first accepted byte. Later bytes with different upper address bits are written into that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_stb | input | 1 | One-cycle strobe: a data byte was received |
| byte_addr | input | ADDR_W | Array address of the strobed byte |
| byte_data | input | DATA_W | Strobed data byte |
| wp | input | 1 | Write protection; strobed bytes are dropped while 1 |
| commit | input | 1 | One-cycle pulse: bus stop ended the write |
| abort | input | 1 | One-cycle pulse: new bus start before stop |
| tick | input | 1 | Prescaler tick that times the programming cycle |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Programming cycle in progress |

## Verification
The bound checker watches four things on every cycle: array writes happen only inside a cycle, a cycle begins only right after a commit, `busy` never falls before the required number of ticks has been seen, and back-to-back writes step by one offset within a single page. The bench scenarios cover the behaviour that depends on data history. These are the overwrite and wrap of repeated offsets, the dropping of protected and busy-time bytes, the discard on abort, the clearing of flags after a cycle, and the page taken from the first byte. For each, the bench compares the logged write port against a model of the expected array contents.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

    localparam int PCW_ADDR_W     = 11;
    localparam int PCW_DATA_W     = 8;
    localparam int PCW_PAGE_BYTES = 32;
    localparam int PCW_TICKS      = 10000;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SCAN = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_e;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/pcw_page_buf.sv
module pcw_page_buf #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int PAGE_W     = 6,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [PAGE_W-1:0]     wr_page,
    input  logic [OFF_W-1:0]      wr_off,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  clear,
    input  logic [OFF_W-1:0]      rd_off,
    output logic [PAGE_BYTES-1:0] slot_vld,
    output logic [DATA_W-1:0]     rd_data,
    output logic [PAGE_W-1:0]     page
);

    logic [DATA_W-1:0] slot_data [PAGE_BYTES];
    logic              any_held;

    assign any_held = |slot_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld <= '0;
            page     <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) begin
                slot_data[i] <= '0;
            end
        end else if (clear) begin
            slot_vld <= '0;
        end else if (wr_en) begin
            if (!any_held) begin
                page <= wr_page;
            end
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (wr_off == OFF_W'(i)) begin
                    slot_vld[i]  <= 1'b1;
                    slot_data[i] <= wr_data;
                end
            end
        end
    end

    assign rd_data = slot_data[rd_off];

endmodule

// File: rtl/pcw_tick_timer.sv
module pcw_tick_timer #(
    parameter int CYCLE_TICKS = 10000,
    localparam int CNT_W      = pcw_pkg::cnt_width(CYCLE_TICKS)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && (cnt < CNT_W'(CYCLE_TICKS))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt >= CNT_W'(CYCLE_TICKS));

endmodule

// File: rtl/pcw_flush_seq.sv
module pcw_flush_seq #(
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  timer_done,
    input  logic [PAGE_BYTES-1:0] slot_vld,
    output logic [OFF_W-1:0]      idx,
    output logic                  scan_we,
    output logic                  busy,
    output logic                  finish
);
    import pcw_pkg::*;

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    idx <= '0;
                    if (start) begin
                        state <= SEQ_SCAN;
                    end
                end
                SEQ_SCAN: begin
                    if (idx == OFF_W'(PAGE_BYTES - 1)) begin
                        state <= SEQ_HOLD;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SEQ_HOLD: begin
                    if (timer_done) begin
                        state <= SEQ_IDLE;
                        idx   <= '0;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy    = (state != SEQ_IDLE);
    assign scan_we = (state == SEQ_SCAN) && slot_vld[idx];
    assign finish  = (state == SEQ_HOLD) && timer_done;

endmodule

// File: rtl/pcw_page_commit.sv
module pcw_page_commit #(
    parameter int ADDR_W      = pcw_pkg::PCW_ADDR_W,
    parameter int DATA_W      = pcw_pkg::PCW_DATA_W,
    parameter int PAGE_BYTES  = pcw_pkg::PCW_PAGE_BYTES,
    parameter int CYCLE_TICKS = pcw_pkg::PCW_TICKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_stb,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              wp,
    input  logic              commit,
    input  logic              abort,
    input  logic              tick,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic [PAGE_BYTES-1:0] slot_vld;
    logic [OFF_W-1:0]      scan_idx;
    logic [PAGE_W-1:0]     cur_page;
    logic [DATA_W-1:0]     scan_data;
    logic                  accept, drop_all, start, timer_done, finish, scan_we;

    assign accept   = byte_stb && !wp && !busy;
    assign drop_all = (abort && !busy) || finish;
    assign start    = commit && !busy && (|slot_vld);

    pcw_page_buf #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_W     (PAGE_W)
    ) u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accept),
        .wr_page  (byte_addr[ADDR_W-1:OFF_W]),
        .wr_off   (byte_addr[OFF_W-1:0]),
        .wr_data  (byte_data),
        .clear    (drop_all),
        .rd_off   (scan_idx),
        .slot_vld (slot_vld),
        .rd_data  (scan_data),
        .page     (cur_page)
    );

    pcw_tick_timer #(
        .CYCLE_TICKS (CYCLE_TICKS)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick),
        .done (timer_done)
    );

    pcw_flush_seq #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .timer_done (timer_done),
        .slot_vld   (slot_vld),
        .idx        (scan_idx),
        .scan_we    (scan_we),
        .busy       (busy),
        .finish     (finish)
    );

    assign mem_we    = scan_we;
    assign mem_addr  = {cur_page, scan_idx};
    assign mem_wdata = scan_data;

endmodule

// File: rtl/pcw_page_commit_chk.sv
module pcw_page_commit_chk #(
    parameter int ADDR_W      = 11,
    parameter int CYCLE_TICKS = 10000
) (
    input logic              clk,
    input logic              rst,
    input logic              commit,
    input logic              tick,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);

    int tick_seen;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            tick_seen <= 0;
        end else if (tick) begin
            tick_seen <= tick_seen + 1;
        end
    end

    // R4
    p_we_in_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R4
    p_start_after_commit_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit));

    // R5
    p_hold_ticks_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(tick_seen) >= CYCLE_TICKS));

    // R7 and R11: consecutive writes step one offset inside one page
    p_scan_order_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

endmodule

bind pcw_page_commit pcw_page_commit_chk #(
    .ADDR_W      (ADDR_W),
    .CYCLE_TICKS (CYCLE_TICKS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .commit   (commit),
    .tick     (tick),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/tb_pcw_page_commit.sv
module tb_pcw_page_commit;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          byte_stb = 1'b0;
    logic [AW-1:0] byte_addr = '0;
    logic [DW-1:0] byte_data = '0;
    logic          wp = 1'b0;
    logic          commit = 1'b0;
    logic          abort = 1'b0;
    logic          tick = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          busy;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    int            log_n = 0;
    logic [AW-1:0] log_a [256];
    logic [DW-1:0] log_d [256];

    always #2.5 clk = ~clk;

    pcw_page_commit #(
        .ADDR_W (AW), .DATA_W (DW), .PAGE_BYTES (32), .CYCLE_TICKS (NT)
    ) dut (
        .clk (clk), .rst (rst), .byte_stb (byte_stb), .byte_addr (byte_addr),
        .byte_data (byte_data), .wp (wp), .commit (commit), .abort (abort),
        .tick (tick), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .busy (busy)
    );

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            log_a[log_n % 256] = mem_addr;
            log_d[log_n % 256] = mem_wdata;
            log_n = log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int pg, input int off);
        return AW'(pg * 32 + (off % 32));
    endfunction

    task automatic send_byte(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit prot);
        byte_stb = 1'b1; byte_addr = a; byte_data = d; wp = prot;
        @(negedge clk);
        byte_stb = 1'b0; wp = 1'b0;
    endtask

    task automatic pulse_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic pulse_abort();
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // lets the offset walk finish, then times the hold precisely
    task automatic finish_cycle(input string req);
        repeat (40) @(negedge clk);
        for (int i = 0; i < NT - 1; i++) pulse_tick();
        check(busy == 1'b1, req, busy, 1);
        pulse_tick();
        check(busy == 1'b1, req, busy, 1);
        @(negedge clk);
        check(busy == 1'b0, req, busy, 0);
    endtask

    // a commit that must not start a cycle
    task automatic expect_no_cycle(input string req);
        int base;
        base = log_n;
        pulse_commit();
        check(busy == 1'b0, req, busy, 0);
        repeat (40) @(negedge clk);
        check(busy == 1'b0, req, busy, 0);
        check(log_n == base, req, log_n - base, 0);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1", busy, 0);
        check(mem_we == 1'b0, "R1", mem_we, 0);
        expect_no_cycle("R1");
    endtask

    task automatic t_basic();
        int base;
        base = log_n;
        send_byte(mk(5, 2), 8'h11, 1'b0);
        send_byte(mk(5, 3), 8'h22, 1'b0);
        send_byte(mk(5, 4), 8'h33, 1'b0);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R4", busy, 0);
        check(log_n == base, "R4", log_n - base, 0);
        pulse_commit();
        check(busy == 1'b1, "R4", busy, 1);
        finish_cycle("R5");
        check(log_n - base == 3, "R2", log_n - base, 3);
        for (int k = 0; k < 3; k++) begin
            check(log_a[(base + k) % 256] == mk(5, 2 + k), "R2",
                  log_a[(base + k) % 256], mk(5, 2 + k));
            check(log_d[(base + k) % 256] == DW'(8'h11 * (k + 1)), "R2",
                  log_d[(base + k) % 256], 8'h11 * (k + 1));
        end
        expect_no_cycle("R7");
    endtask

    task automatic t_wrap();
        int base;
        base = log_n;
        for (int i = 0; i < 33; i++) send_byte(mk(2, i), DW'(i + 1), 1'b0);
        pulse_commit();
        finish_cycle("R3");
        check(log_n - base == 32, "R3", log_n - base, 32);
        for (int k = 0; k < 32; k++) begin
            check(log_a[(base + k) % 256] == mk(2, k), "R3", log_a[(base + k) % 256], mk(2, k));
            check(log_d[(base + k) % 256] == DW'((k == 0) ? 33 : k + 1), "R3",
                  log_d[(base + k) % 256], (k == 0) ? 33 : k + 1);
        end
    endtask

    task automatic t_protect();
        send_byte(mk(6, 1), 8'hAA, 1'b1);
        send_byte(mk(6, 2), 8'hBB, 1'b1);
        expect_no_cycle("R6");
    endtask

    task automatic t_empty();
        expect_no_cycle("R8");
    endtask

    task automatic t_abort();
        int base;
        send_byte(mk(7, 5), 8'h55, 1'b0);
        send_byte(mk(7, 6), 8'h66, 1'b0);
        pulse_abort();
        expect_no_cycle("R9");
        base = log_n;
        send_byte(mk(8, 9), 8'h99, 1'b0);
        pulse_commit();
        finish_cycle("R9");
        check(log_n - base == 1, "R9", log_n - base, 1);
        check(log_a[base % 256] == mk(8, 9), "R9", log_a[base % 256], mk(8, 9));
        check(log_d[base % 256] == 8'h99, "R9", log_d[base % 256], 8'h99);
    endtask

    task automatic t_busy_ignore();
        int base;
        base = log_n;
        send_byte(mk(10, 0), 8'h01, 1'b0);
        pulse_commit();
        send_byte(mk(10, 9), 8'hEE, 1'b0);
        pulse_abort();
        pulse_commit();
        finish_cycle("R10");
        check(log_n - base == 1, "R10", log_n - base, 1);
        check(log_a[base % 256] == mk(10, 0), "R10", log_a[base % 256], mk(10, 0));
        expect_no_cycle("R10");
    endtask

    task automatic t_page();
        int base;
        base = log_n;
        send_byte(mk(3, 1), 8'h31, 1'b0);
        send_byte(mk(4, 2), 8'h42, 1'b0);
        pulse_commit();
        finish_cycle("R11");
        check(log_n - base == 2, "R11", log_n - base, 2);
        check(log_a[(base + 1) % 256] == mk(3, 2), "R11", log_a[(base + 1) % 256], mk(3, 2));
        check(log_d[(base + 1) % 256] == 8'h42, "R11", log_d[(base + 1) % 256], 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_protect();
        t_empty();
        t_abort();
        t_busy_ignore();
        t_page();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule